// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control unit of a multi-cycle load/store processor. It steps each instruction through fetch, decode, execute, memory access and write-back. Each step takes one clock cycle, and each instruction uses only the steps it needs. The block takes three inputs: the 6-bit primary opcode from the instruction register, an operand-equality flag from the datapath comparator, and the ALU overflow flag. From its current state alone it drives every datapath control: PC write and PC source, instruction register write, branch target register write, register file write with destination and data selects, memory read and write with the address select, both ALU operand selects, and the ALU operation.

Five instruction classes are supported: register-register (R-type), OR with immediate, load word, store word and branch-if-equal. An unconditional jump also gets its own state. Two trap states handle errors. One catches opcodes that have no defined path. The other catches arithmetic overflow during R-type execution. Each trap makes the ALU compute PC minus 4 and writes that value into the exception PC register. It also writes a cause code and loads the PC with the fixed handler address. The datapath, memory and register file sit outside the block and act on these controls.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes 0000. While `rst` is high, `pc_wr`, `ir_wr`, `tgt_wr`, `reg_wr`, `mem_rd`, `mem_wr`, `epc_wr` and `cause_wr` are all 0.
- R2: State 0000 (fetch) asserts `mem_rd` with `addr_sel`=0 and `ir_wr`. It also asserts `pc_wr` with `pc_src`=00 and sets the ALU to PC+4 (`alu_a_sel`=0, `alu_b_sel`=001, `alu_op`=00). The next state is always 0001.
- R3: State 0001 (decode) asserts `tgt_wr` and sets the ALU to PC plus the shifted sign-extended immediate (`alu_a_sel`=0, `alu_b_sel`=011, `alu_op`=00). The next state is selected by opcode:
  - 000000 (R-type) goes to 0100.
  - 001101 (OR-immediate) goes to 0110.
  - 100011 (load) goes to 1000.
  - 101011 (store) goes to 1011.
  - 000010 (jump) goes to 1101.
  - 000100 (branch) goes to 0011 if `ops_equal`=1, otherwise to 0010.
  - Any other opcode goes to 1110.
- R4: State 0100 drives `alu_a_sel`=1, `alu_b_sel`=000 and `alu_op`=10. Without overflow it moves to 0101. State 0101 asserts `reg_wr` with `reg_dst`=1 and `mem_to_reg`=0, then returns to 0000.
- R5: If `alu_ovf` is high in state 0100, the next state is 1111 and `reg_wr` stays 0. State 1111 asserts `epc_wr`, `cause_wr` with `cause`=12 and `pc_wr` with `pc_src`=11 (handler address). It drives the ALU to PC-4 (`alu_a_sel`=0, `alu_b_sel`=001, `alu_op`=01) and then returns to 0000.
- R6: State 0110 drives `alu_a_sel`=1, `alu_b_sel`=100 and `alu_op`=11, then moves to 0111. State 0111 asserts `reg_wr` with `reg_dst`=0 and `mem_to_reg`=0, then returns to 0000. `alu_ovf` has no effect on this path.
- R7: Load runs 1000, 1001, 1010, 0000.
  - State 1000 drives `alu_a_sel`=1, `alu_b_sel`=010 and `alu_op`=00.
  - State 1001 asserts `mem_rd` with `addr_sel`=1.
  - State 1010 asserts `reg_wr` with `reg_dst`=0 and `mem_to_reg`=1.
  - `alu_ovf` and `ops_equal` have no effect on this path.
- R8: Store runs 1011, 1100, 0000. State 1011 drives the same ALU selects as 1000. State 1100 asserts `mem_wr` with `addr_sel`=1.
- R9: State 0011 asserts `pc_wr` with `pc_src`=01 (target register). State 0010 asserts no enable. Both return to 0000.
- R10: State 1101 asserts `pc_wr` with `pc_src`=10 (jump address) and returns to 0000.
- R11: State 1110 drives the same controls as 1111 except that `cause`=10, and it returns to 0000.
- R12: Every control field not named for the current state is 0. `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Primary opcode field from the instruction register |
| ops_equal | input | 1 | High when the two source operands compare equal |
| alu_ovf | input | 1 | ALU arithmetic overflow flag |
| state | output | 4 | Current sequencer state |
| pc_wr | output | 1 | Write the PC |
| pc_src | output | 2 | PC source: 00 ALU, 01 target, 10 jump, 11 handler |
| ir_wr | output | 1 | Load the instruction register from memory |
| tgt_wr | output | 1 | Load the branch target register from the ALU |
| reg_wr | output | 1 | Write the register file |
| reg_dst | output | 1 | Destination register: 0 rt, 1 rd |
| mem_to_reg | output | 1 | Register write data: 0 ALU result, 1 memory |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU result |
| alu_a_sel | output | 1 | First ALU operand: 0 PC, 1 rs |
| alu_b_sel | output | 3 | Second ALU operand select |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 function code, 11 OR |
| epc_wr | output | 1 | Write the exception PC from the ALU |
| cause_wr | output | 1 | Write the cause register |
| cause | output | 4 | Exception cause code |

## Verification
Each instruction class is run through the sequencer, and the state and every control field are compared cycle by cycle. This covers the dispatch and each path's control pattern. The branch is run with equal and unequal operands, which separates the taken and not-taken states. R-type is run with and without overflow, which separates normal write-back from the trap. Load and OR-immediate run with overflow and equality held high, which shows that those flags only matter in their own states. Two different unassigned opcodes exercise the undefined-instruction trap, and the jump opcode confirms it is not treated as undefined.

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm (
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic       ops_equal,
  input  logic       alu_ovf,
  output logic [3:0] state,
  output logic       pc_wr,
  output logic [1:0] pc_src,
  output logic       ir_wr,
  output logic       tgt_wr,
  output logic       reg_wr,
  output logic       reg_dst,
  output logic       mem_to_reg,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       addr_sel,
  output logic       alu_a_sel,
  output logic [2:0] alu_b_sel,
  output logic [1:0] alu_op,
  output logic       epc_wr,
  output logic       cause_wr,
  output logic [3:0] cause
);
  localparam logic [3:0] S_FETCH  = 4'd0,  S_DECODE = 4'd1,  S_BR_NT  = 4'd2,
                         S_BR_T   = 4'd3,  S_R_EXE  = 4'd4,  S_R_WB   = 4'd5,
                         S_OI_EXE = 4'd6,  S_OI_WB  = 4'd7,  S_LD_ADR = 4'd8,
                         S_LD_MEM = 4'd9,  S_LD_WB  = 4'd10, S_ST_ADR = 4'd11,
                         S_ST_MEM = 4'd12, S_JUMP   = 4'd13, S_T_UNDEF = 4'd14,
                         S_T_OVF  = 4'd15;
  localparam logic [5:0] OP_RTYPE = 6'h00, OP_ORI = 6'h0d, OP_LW = 6'h23,
                         OP_SW = 6'h2b, OP_BEQ = 6'h04, OP_J = 6'h02;
  localparam logic [3:0] CAUSE_UNDEF = 4'd10, CAUSE_OVF = 4'd12;

  logic [3:0] st, nxt;
  logic pc_wr_c, ir_wr_c, tgt_wr_c, reg_wr_c, mem_rd_c, mem_wr_c, epc_wr_c, cause_wr_c;

  always_ff @(posedge clk)
    if (rst) st <= S_FETCH;
    else     st <= nxt;

  always_comb begin
    nxt = S_FETCH;
    case (st)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE:
        case (opcode)
          OP_RTYPE: nxt = S_R_EXE;
          OP_ORI:   nxt = S_OI_EXE;
          OP_LW:    nxt = S_LD_ADR;
          OP_SW:    nxt = S_ST_ADR;
          OP_J:     nxt = S_JUMP;
          OP_BEQ:   nxt = ops_equal ? S_BR_T : S_BR_NT;
          default:  nxt = S_T_UNDEF;
        endcase
      S_R_EXE:  nxt = alu_ovf ? S_T_OVF : S_R_WB;
      S_OI_EXE: nxt = S_OI_WB;
      S_LD_ADR: nxt = S_LD_MEM;
      S_LD_MEM: nxt = S_LD_WB;
      S_ST_ADR: nxt = S_ST_MEM;
      default:  nxt = S_FETCH;
    endcase
  end

  always_comb begin
    pc_wr_c = 1'b0; ir_wr_c = 1'b0; tgt_wr_c = 1'b0; reg_wr_c = 1'b0;
    mem_rd_c = 1'b0; mem_wr_c = 1'b0; epc_wr_c = 1'b0; cause_wr_c = 1'b0;
    pc_src = 2'b00; reg_dst = 1'b0; mem_to_reg = 1'b0; addr_sel = 1'b0;
    alu_a_sel = 1'b0; alu_b_sel = 3'b000; alu_op = 2'b00; cause = 4'd0;
    case (st)
      S_FETCH: begin
        mem_rd_c = 1'b1; ir_wr_c = 1'b1; pc_wr_c = 1'b1; alu_b_sel = 3'b001;
      end
      S_DECODE: begin
        tgt_wr_c = 1'b1; alu_b_sel = 3'b011;
      end
      S_BR_T: begin
        pc_wr_c = 1'b1; pc_src = 2'b01;
      end
      S_R_EXE: begin
        alu_a_sel = 1'b1; alu_op = 2'b10;
      end
      S_R_WB: begin
        reg_wr_c = 1'b1; reg_dst = 1'b1;
      end
      S_OI_EXE: begin
        alu_a_sel = 1'b1; alu_b_sel = 3'b100; alu_op = 2'b11;
      end
      S_OI_WB:  reg_wr_c = 1'b1;
      S_LD_ADR, S_ST_ADR: begin
        alu_a_sel = 1'b1; alu_b_sel = 3'b010;
      end
      S_LD_MEM: begin
        mem_rd_c = 1'b1; addr_sel = 1'b1;
      end
      S_LD_WB: begin
        reg_wr_c = 1'b1; mem_to_reg = 1'b1;
      end
      S_ST_MEM: begin
        mem_wr_c = 1'b1; addr_sel = 1'b1;
      end
      S_JUMP: begin
        pc_wr_c = 1'b1; pc_src = 2'b10;
      end
      S_T_UNDEF, S_T_OVF: begin
        epc_wr_c = 1'b1; cause_wr_c = 1'b1; pc_wr_c = 1'b1; pc_src = 2'b11;
        alu_b_sel = 3'b001; alu_op = 2'b01;
        cause = (st == S_T_OVF) ? CAUSE_OVF : CAUSE_UNDEF;
      end
      default: ;
    endcase
  end

  assign state    = st;
  assign pc_wr    = pc_wr_c    & ~rst;
  assign ir_wr    = ir_wr_c    & ~rst;
  assign tgt_wr   = tgt_wr_c   & ~rst;
  assign reg_wr   = reg_wr_c   & ~rst;
  assign mem_rd   = mem_rd_c   & ~rst;
  assign mem_wr   = mem_wr_c   & ~rst;
  assign epc_wr   = epc_wr_c   & ~rst;
  assign cause_wr = cause_wr_c & ~rst;
endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk (
  input logic       clk,
  input logic       rst,
  input logic [5:0] opcode,
  input logic       ops_equal,
  input logic       alu_ovf,
  input logic [3:0] state,
  input logic       pc_wr,
  input logic [1:0] pc_src,
  input logic       ir_wr,
  input logic       tgt_wr,
  input logic       reg_wr,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       epc_wr,
  input logic       cause_wr,
  input logic [3:0] cause
);
  logic op_known;
  assign op_known = (opcode == 6'h00) || (opcode == 6'h0d) || (opcode == 6'h23) ||
                    (opcode == 6'h2b) || (opcode == 6'h04) || (opcode == 6'h02);

  always_comb
    if (rst)
      assert_quiet_in_reset_R1: assert (!(pc_wr | ir_wr | tgt_wr | reg_wr | mem_rd |
                                          mem_wr | epc_wr | cause_wr));

  assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (rst)
    state == 4'd0 |=> state == 4'd1);

  assert_ovf_trap_R5: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd4 && alu_ovf) |=> (!reg_wr && cause_wr && cause == 4'd12 && pc_src == 2'b11));

  assert_load_seq_R7: assert property (@(posedge clk) disable iff (rst)
    state == 4'd9 |=> (state == 4'd10 && reg_wr));

  assert_beq_taken_R9: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd1 && opcode == 6'h04 && ops_equal) |=> (pc_wr && pc_src == 2'b01));

  assert_undef_cause_R11: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd1 && !op_known) |=> (epc_wr && cause_wr && cause == 4'd10));

  assert_mem_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk u_chk (.*);

// File: tb/test_mc_ctrl_fsm.sv
module test_mc_ctrl_fsm;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, ops_equal = 1'b0, alu_ovf = 1'b0;
  logic [5:0] opcode = 6'h00;
  logic [3:0] state, cause;
  logic pc_wr, ir_wr, tgt_wr, reg_wr, reg_dst, mem_to_reg, mem_rd, mem_wr;
  logic addr_sel, alu_a_sel, epc_wr, cause_wr;
  logic [1:0] pc_src, alu_op;
  logic [2:0] alu_b_sel;

  int checks = 0, fails = 0, cycles = 0;
  int m_st = 0, m_prev = 0;
  bit chk_en = 0, done = 0;

  mc_ctrl_fsm i_mc_ctrl_fsm (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [22:0] dut_vec;
  assign dut_vec = {pc_wr, pc_src, ir_wr, tgt_wr, reg_wr, reg_dst, mem_to_reg, mem_rd,
                    mem_wr, addr_sel, alu_a_sel, alu_b_sel, alu_op, epc_wr, cause_wr, cause};

  function automatic logic [22:0] expect_vec(int s, bit r);
    int pw = 0, ps = 0, iw = 0, tw = 0, rw = 0, rd = 0, m2r = 0, mr = 0, mw = 0;
    int as = 0, aa = 0, ab = 0, ao = 0, ew = 0, cw = 0, cz = 0;
    if (s == 0) begin mr = 1; iw = 1; pw = 1; ab = 1; end
    if (s == 1) begin tw = 1; ab = 3; end
    if (s == 3) begin pw = 1; ps = 1; end
    if (s == 4) begin aa = 1; ao = 2; end
    if (s == 5) begin rw = 1; rd = 1; end
    if (s == 6) begin aa = 1; ab = 4; ao = 3; end
    if (s == 7) rw = 1;
    if (s == 8 || s == 11) begin aa = 1; ab = 2; end
    if (s == 9) begin mr = 1; as = 1; end
    if (s == 10) begin rw = 1; m2r = 1; end
    if (s == 12) begin mw = 1; as = 1; end
    if (s == 13) begin pw = 1; ps = 2; end
    if (s >= 14) begin ew = 1; cw = 1; pw = 1; ps = 3; ab = 1; ao = 1; cz = (s == 15) ? 12 : 10; end
    if (r) begin pw = 0; iw = 0; tw = 0; rw = 0; mr = 0; mw = 0; ew = 0; cw = 0; end
    return {pw[0], ps[1:0], iw[0], tw[0], rw[0], rd[0], m2r[0], mr[0], mw[0], as[0], aa[0],
            ab[2:0], ao[1:0], ew[0], cw[0], cz[3:0]};
  endfunction

  function automatic string req_of(int s);
    case (s)
      0: return "R2";  1: return "R3";  2, 3: return "R9";  4, 5: return "R4";
      6, 7: return "R6";  8, 9, 10: return "R7";  11, 12: return "R8";
      13: return "R10";  14: return "R11";  default: return "R5";
    endcase
  endfunction

  always @(posedge clk) begin
    m_prev <= m_st;
    if (rst) m_st <= 0;
    else case (m_st)
      1: case (opcode)
           6'h00: m_st <= 4;   6'h0d: m_st <= 6;   6'h23: m_st <= 8;
           6'h2b: m_st <= 11;  6'h02: m_st <= 13;  6'h04: m_st <= ops_equal ? 3 : 2;
           default: m_st <= 14;
         endcase
      4: m_st <= alu_ovf ? 15 : 5;
      0: m_st <= 1;
      6, 8, 9, 11: m_st <= m_st + 1;
      default: m_st <= 0;
    endcase
  end

  always @(negedge clk) if (chk_en) begin
    string rq;
    rq = rst ? "R1" : req_of(m_st);
    checks++;
    if (state !== m_st[3:0]) begin
      fails++;
      $display("FAIL %s state actual=%0d expected=%0d", rst ? "R1" : req_of(m_prev), state, m_st);
    end
    checks++;
    if (dut_vec !== expect_vec(m_st, rst)) begin
      fails++;
      $display("FAIL %s controls in state %0d actual=%h expected=%h", rq, m_st, dut_vec,
               expect_vec(m_st, rst));
    end
    checks++;
    if (mem_rd && mem_wr) begin
      fails++;
      $display("FAIL R12 mem_rd/mem_wr actual=11 expected=not both");
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d cycles expected=below 20000", cycles);
      finish_run();
    end
  end

  task automatic run_instr(input logic [5:0] op, input logic eq, input logic ovf);
    opcode = op; ops_equal = eq; alu_ovf = ovf;
    do begin
      @(negedge clk); #1;
    end while (m_st != 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    chk_en = 1;
    @(negedge clk); #1;
    @(negedge clk); #1;
    rst = 1'b0;
    run_instr(6'h0d, 1'b0, 1'b0);
    run_instr(6'h04, 1'b1, 1'b0);
    run_instr(6'h04, 1'b0, 1'b0);
    run_instr(6'h00, 1'b0, 1'b0);
    run_instr(6'h00, 1'b0, 1'b1);
    run_instr(6'h23, 1'b0, 1'b0);
    run_instr(6'h2b, 1'b0, 1'b0);
    run_instr(6'h02, 1'b0, 1'b0);
    run_instr(6'h3f, 1'b0, 1'b0);
    run_instr(6'h01, 1'b1, 1'b1);
    run_instr(6'h23, 1'b1, 1'b1);
    run_instr(6'h0d, 1'b1, 1'b1);
    run_instr(6'h00, 1'b1, 1'b0);
    run_instr(6'h2b, 1'b1, 1'b1);
    rst = 1'b1;
    @(negedge clk); #1;
    @(negedge clk); #1;
    rst = 1'b0;
    run_instr(6'h04, 1'b1, 1'b1);
    @(negedge clk);
    finish_run();
  end
endmodule